// File: doc/BRIEF.md
# Control Endpoint Handshake Sequencer

This block runs the control-transfer protocol of endpoint zero in a USB device. A packet layer in front of it has already decoded tokens, data packets and host handshakes; the sequencer works out which handshake the device must return (ACK, NAK or STALL), or whether it must send a data packet, and which data PID that packet carries. Behind it, firmware sees a small register set: a handshake-hold bit, a stall bit, strobes that arm one IN or one OUT data packet, and three write-1-to-clear interrupt flags.

A transfer opens with a SETUP token. The 8-byte setup packet that follows is acknowledged, and firmware is interrupted twice: once for the token and once when the setup bytes are available. Data-stage packets behave like bulk traffic. They are acknowledged only once firmware has armed a byte count, and their PID toggles from DATA1. The status stage is held off with NAK until firmware releases the hold bit. Firmware may instead stall the transfer. A new SETUP token aborts any transfer in progress.

States: `ST_IDLE` (0, no transfer), `ST_SETUP_RX` (1, waiting for the setup bytes), `ST_OPEN` (2, data or status pending), `ST_IN_WAIT` (3, IN data sent, waiting for the host ACK), `ST_STAT_WAIT` (4, zero-length status packet sent). The transitions are:
- a SETUP token from any state goes to `ST_SETUP_RX`;
- a valid setup packet goes from `ST_SETUP_RX` to `ST_OPEN`, and any other packet goes from `ST_SETUP_RX` to `ST_IDLE`;
- an IN token with an armed count goes to `ST_IN_WAIT`;
- an IN token with the hold released and nothing armed goes to `ST_STAT_WAIT`;
- a host ACK goes from `ST_IN_WAIT` back to `ST_OPEN`, or from `ST_STAT_WAIT` to `ST_IDLE`;
- an accepted zero-length OUT status packet goes from `ST_OPEN` to `ST_IDLE`;
- a stalled IN token returns to `ST_OPEN`.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset, `ctl_state` is 0 (idle), `resp_valid`, `hsnak`, `stall` and all of `irq` are 0.
- R2: A SETUP token (`tok_kind` 0) moves `ctl_state` to 1 in the next cycle, sets `hsnak` to 1 and `irq[0]` to 1, clears `stall` and both armed counts, and resets the data toggle. This aborts any transfer in progress.
- R3: In state 1, only a data packet of exactly 8 bytes with PID DATA0 (`rx_data1`=0) is answered with ACK. That packet sets `irq[1]` and moves to state 2. Any other packet gets no response and returns to state 0.
- R4: With an IN count armed, an IN token (`tok_kind` 1) is answered with a data packet (`resp_code` 0), `tx_len` equal to the armed count, and the current toggle on `tx_data1`. The toggle starts at DATA1 after the setup packet. Each host ACK flips it, disarms the IN count and sets `irq[2]`. A retried IN token before the host ACK resends the same PID.
- R5: With an OUT count armed, a data packet whose PID matches the toggle is ACKed (`resp_code` 1), flips the toggle and disarms the count. A packet with the wrong PID is ACKed but changes neither the toggle nor the arming.
- R6: While `hsnak` is 1 and nothing is armed, IN tokens and OUT data packets in states 2 to 4 are answered with NAK (`resp_code` 2).
- R7: A firmware write of 1 (`fw_hsnak_clr`) clears `hsnak`. After that:
  - an IN token with nothing armed gets a zero-length DATA1 packet and moves to state 4, and the host ACK returns to state 0 without setting `irq[2]`;
  - a zero-length DATA1 OUT packet with nothing armed is ACKed and returns to state 0.
- R8: `fw_stall_set` sets `stall`, and only a SETUP token clears it. While it is set, IN tokens and OUT data packets outside state 1 are answered with STALL (`resp_code` 3).
- R9: The `irq` flags are write-1-to-clear through `fw_irq_clr`. When a clear and a set reach the same flag in the same cycle, the set wins. A SETUP token in the same cycle as `fw_hsnak_clr` leaves `hsnak` at 1.
- R10: In state 0, IN tokens and data packets are answered with NAK, or with STALL if `stall` is set.
- R11: The response appears on `resp_valid`/`resp_code`/`tx_data1`/`tx_len` in the cycle after the event and lasts one cycle. Events are single-cycle strobes, at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token for endpoint zero received |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT |
| rx_valid | input | 1 | Data packet received |
| rx_data1 | input | 1 | Received PID is DATA1 (0 = DATA0) |
| rx_len | input | LEN_W | Received byte count |
| host_ack | input | 1 | Host ACK after device data |
| fw_hsnak_clr | input | 1 | Firmware writes 1 to the hold bit |
| fw_stall_set | input | 1 | Firmware sets the stall bit |
| fw_in_arm | input | 1 | Firmware arms one IN packet |
| fw_in_len | input | LEN_W | Byte count for the armed IN packet |
| fw_out_arm | input | 1 | Firmware arms one OUT packet |
| fw_irq_clr | input | 3 | Write-1-to-clear mask for `irq` |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 2 | 0 DATA, 1 ACK, 2 NAK, 3 STALL |
| tx_data1 | output | 1 | PID for sent data: 1 = DATA1 |
| tx_len | output | LEN_W | Byte count of sent data |
| ctl_state | output | 3 | Sequencer state code |
| hsnak | output | 1 | Status-stage hold bit |
| stall | output | 1 | Stall bit |
| irq | output | 3 | Flags: 0 setup token, 1 setup data, 2 IN done |

## Verification
The bench sweeps every setup packet length from 0 to 15 with both PIDs. A design that checked the length or the PID loosely would ACK a malformed setup packet or stay in the setup state. It also runs IN data stages of one to four packets, including a retried token. A toggle that flipped on transmission instead of on the host ACK would show a wrong PID on the retry or on the packet after it. OUT packets with a stale PID must be ACKed without consuming the arm, and a stale-PID packet that disarmed the count would NAK the next good packet. The remaining cases are the collisions:
- a SETUP token arriving mid-transfer with an armed count, which must be discarded;
- a stall set while idle;
- a flag clear or hold-bit clear landing in the same cycle as the hardware set.

A design that let the clear win would lose the interrupt or release the status stage early.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
    localparam int IRQ_N = 3;
    localparam int IRQ_SUTOK = 0;
    localparam int IRQ_SUDATA = 1;
    localparam int IRQ_INDONE = 2;

    typedef enum logic [1:0] {
        TK_SETUP = 2'd0,
        TK_IN    = 2'd1,
        TK_OUT   = 2'd2
    } tok_e;

    typedef enum logic [1:0] {
        RSP_DATA  = 2'd0,
        RSP_ACK   = 2'd1,
        RSP_NAK   = 2'd2,
        RSP_STALL = 2'd3
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SETUP_RX  = 3'd1,
        ST_OPEN      = 3'd2,
        ST_IN_WAIT   = 3'd3,
        ST_STAT_WAIT = 3'd4
    } ctl_state_e;
endpackage

// File: rtl/ctl_ep_regs.sv
module ctl_ep_regs
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_setup_tok,
    input  logic             ev_setup_ok,
    input  logic             ev_in_done,
    input  logic             ev_out_done,
    input  logic             fw_hsnak_clr,
    input  logic             fw_stall_set,
    input  logic             fw_in_arm,
    input  logic [LEN_W-1:0] fw_in_len,
    input  logic             fw_out_arm,
    input  logic [IRQ_N-1:0] fw_irq_clr,
    output logic             hsnak,
    output logic             stall,
    output logic             in_armed,
    output logic [LEN_W-1:0] in_len,
    output logic             out_armed,
    output logic [IRQ_N-1:0] irq
);
    logic [IRQ_N-1:0] irq_set;

    assign irq_set[IRQ_SUTOK]  = ev_setup_tok;
    assign irq_set[IRQ_SUDATA] = ev_setup_ok;
    assign irq_set[IRQ_INDONE] = ev_in_done;

    // Hardware set beats firmware clear on every flag.
    for (genvar i = 0; i < IRQ_N; i++) begin : g_irq
        always_ff @(posedge clk) begin
            if (!rst_n)          irq[i] <= 1'b0;
            else if (irq_set[i]) irq[i] <= 1'b1;
            else if (fw_irq_clr[i]) irq[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsnak     <= 1'b0;
            stall     <= 1'b0;
            in_armed  <= 1'b0;
            in_len    <= '0;
            out_armed <= 1'b0;
        end else begin
            if (ev_setup_tok)      hsnak <= 1'b1;
            else if (fw_hsnak_clr) hsnak <= 1'b0;

            if (ev_setup_tok)      stall <= 1'b0;
            else if (fw_stall_set) stall <= 1'b1;

            if (ev_setup_tok) begin
                in_armed <= 1'b0;
            end else if (fw_in_arm) begin
                in_armed <= 1'b1;
                in_len   <= fw_in_len;
            end else if (ev_in_done) begin
                in_armed <= 1'b0;
            end

            if (ev_setup_tok)     out_armed <= 1'b0;
            else if (fw_out_arm)  out_armed <= 1'b1;
            else if (ev_out_done) out_armed <= 1'b0;
        end
    end
endmodule

// File: rtl/ctl_ep_fsm.sv
module ctl_ep_fsm
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W       = 7,
    parameter int SETUP_BYTES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             rx_valid,
    input  logic             rx_data1,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             host_ack,
    input  logic             hsnak,
    input  logic             stall,
    input  logic             in_armed,
    input  logic [LEN_W-1:0] in_len,
    input  logic             out_armed,
    output logic             resp_valid,
    output rsp_e             resp_code,
    output logic             tx_data1,
    output logic [LEN_W-1:0] tx_len,
    output ctl_state_e       state,
    output logic             ev_setup_tok,
    output logic             ev_setup_ok,
    output logic             ev_in_done,
    output logic             ev_out_done
);
    localparam logic [LEN_W-1:0] SETUP_LEN = LEN_W'(SETUP_BYTES);

    ctl_state_e       st_n;
    logic             tog_q, tog_n;
    logic             rv_n, pid_n;
    rsp_e             rc_n;
    logic [LEN_W-1:0] len_n;
    logic             is_setup, is_in;

    assign is_setup = tok_valid && (tok_kind == TK_SETUP);
    assign is_in    = tok_valid && (tok_kind == TK_IN);

    always_comb begin
        st_n         = state;
        tog_n        = tog_q;
        rv_n         = 1'b0;
        rc_n         = RSP_NAK;
        pid_n        = 1'b0;
        len_n        = '0;
        ev_setup_tok = 1'b0;
        ev_setup_ok  = 1'b0;
        ev_in_done   = 1'b0;
        ev_out_done  = 1'b0;
        if (is_setup) begin
            st_n         = ST_SETUP_RX;
            tog_n        = 1'b0;
            ev_setup_tok = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (is_in || rx_valid) begin
                        rv_n = 1'b1;
                        rc_n = stall ? RSP_STALL : RSP_NAK;
                    end
                end
                ST_SETUP_RX: begin
                    if (rx_valid) begin
                        if (rx_len == SETUP_LEN && !rx_data1) begin
                            rv_n        = 1'b1;
                            rc_n        = RSP_ACK;
                            ev_setup_ok = 1'b1;
                            tog_n       = 1'b1;
                            st_n        = ST_OPEN;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                end
                default: begin
                    if (is_in) begin
                        rv_n = 1'b1;
                        if (stall) begin
                            rc_n = RSP_STALL;
                            st_n = ST_OPEN;
                        end else if (in_armed) begin
                            rc_n  = RSP_DATA;
                            pid_n = tog_q;
                            len_n = in_len;
                            st_n  = ST_IN_WAIT;
                        end else if (hsnak) begin
                            rc_n = RSP_NAK;
                        end else begin
                            rc_n  = RSP_DATA;
                            pid_n = 1'b1;
                            st_n  = ST_STAT_WAIT;
                        end
                    end else if (rx_valid) begin
                        rv_n = 1'b1;
                        if (stall) begin
                            rc_n = RSP_STALL;
                        end else if (out_armed) begin
                            rc_n = RSP_ACK;
                            if (rx_data1 == tog_q) begin
                                tog_n       = ~tog_q;
                                ev_out_done = 1'b1;
                            end
                        end else if (hsnak) begin
                            rc_n = RSP_NAK;
                        end else if (rx_len == '0 && rx_data1) begin
                            rc_n = RSP_ACK;
                            st_n = ST_IDLE;
                        end else begin
                            rc_n = RSP_NAK;
                        end
                    end else if (host_ack) begin
                        if (state == ST_IN_WAIT) begin
                            tog_n      = ~tog_q;
                            ev_in_done = 1'b1;
                            st_n       = ST_OPEN;
                        end else if (state == ST_STAT_WAIT) begin
                            st_n = ST_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            tog_q <= 1'b0;
        end else begin
            state <= st_n;
            tog_q <= tog_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_code  <= RSP_NAK;
            tx_data1   <= 1'b0;
            tx_len     <= '0;
        end else begin
            resp_valid <= rv_n;
            resp_code  <= rc_n;
            tx_data1   <= pid_n;
            tx_len     <= len_n;
        end
    end
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_valid,
    input  logic [1:0]       tok_kind,
    input  logic             rx_valid,
    input  logic             rx_data1,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             host_ack,
    input  logic             fw_hsnak_clr,
    input  logic             fw_stall_set,
    input  logic             fw_in_arm,
    input  logic [LEN_W-1:0] fw_in_len,
    input  logic             fw_out_arm,
    input  logic [2:0]       fw_irq_clr,
    output logic             resp_valid,
    output logic [1:0]       resp_code,
    output logic             tx_data1,
    output logic [LEN_W-1:0] tx_len,
    output logic [2:0]       ctl_state,
    output logic             hsnak,
    output logic             stall,
    output logic [2:0]       irq
);
    logic             ev_setup_tok, ev_setup_ok, ev_in_done, ev_out_done;
    logic             in_armed, out_armed;
    logic [LEN_W-1:0] in_len;
    rsp_e             rc;
    ctl_state_e       st;

    ctl_ep_regs #(.LEN_W(LEN_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ev_setup_tok(ev_setup_tok), .ev_setup_ok(ev_setup_ok),
        .ev_in_done(ev_in_done), .ev_out_done(ev_out_done),
        .fw_hsnak_clr(fw_hsnak_clr), .fw_stall_set(fw_stall_set),
        .fw_in_arm(fw_in_arm), .fw_in_len(fw_in_len),
        .fw_out_arm(fw_out_arm), .fw_irq_clr(fw_irq_clr),
        .hsnak(hsnak), .stall(stall), .in_armed(in_armed),
        .in_len(in_len), .out_armed(out_armed), .irq(irq)
    );

    ctl_ep_fsm #(.LEN_W(LEN_W), .SETUP_BYTES(8)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .tok_valid(tok_valid), .tok_kind(tok_kind),
        .rx_valid(rx_valid), .rx_data1(rx_data1), .rx_len(rx_len),
        .host_ack(host_ack), .hsnak(hsnak), .stall(stall),
        .in_armed(in_armed), .in_len(in_len), .out_armed(out_armed),
        .resp_valid(resp_valid), .resp_code(rc), .tx_data1(tx_data1),
        .tx_len(tx_len), .state(st),
        .ev_setup_tok(ev_setup_tok), .ev_setup_ok(ev_setup_ok),
        .ev_in_done(ev_in_done), .ev_out_done(ev_out_done)
    );

    assign resp_code = rc;
    assign ctl_state = st;
endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk #(
    parameter int LEN_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tok_valid,
    input logic [1:0]       tok_kind,
    input logic [2:0]       fw_irq_clr,
    input logic             resp_valid,
    input logic [1:0]       resp_code,
    input logic             tx_data1,
    input logic [LEN_W-1:0] tx_len,
    input logic [2:0]       ctl_state,
    input logic             hsnak,
    input logic             stall,
    input logic [2:0]       irq
);
    AST_SETUP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_kind == 2'd0) |=> (ctl_state == 3'd1 && hsnak && !stall && irq[0])); // R2

    AST_STALL_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_code == 2'd0 || resp_code == 2'd1) && $past(ctl_state) >= 3'd2)
        |-> !$past(stall)); // R8

    AST_STATUS_IN_DATA1: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd0 && ctl_state == 3'd4)
        |-> (tx_data1 && tx_len == '0 && !$past(hsnak))); // R7

    AST_STATUS_OUT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_code == 2'd1 && $past(ctl_state) >= 3'd2 && ctl_state == 3'd0)
        |-> !$past(hsnak)); // R7

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(irq) & ~$past(fw_irq_clr) & ~irq) == 3'b000)); // R9

    AST_IDLE_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && $past(ctl_state) == 3'd0) |-> (resp_code == 2'd2 || resp_code == 2'd3)); // R10
endmodule

bind ctl_ep_seq ctl_ep_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
    .fw_irq_clr(fw_irq_clr), .resp_valid(resp_valid), .resp_code(resp_code),
    .tx_data1(tx_data1), .tx_len(tx_len), .ctl_state(ctl_state),
    .hsnak(hsnak), .stall(stall), .irq(irq)
);

// File: tb/ctl_ep_seq_bench.sv
`timescale 1ns/1ps
module ctl_ep_seq_bench;
    localparam int LEN_W = 7;
    localparam int R_DATA = 0, R_ACK = 1, R_NAK = 2, R_STALL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_valid = 1'b0;
    logic [1:0] tok_kind = 2'd0;
    logic rx_valid = 1'b0, rx_data1 = 1'b0;
    logic [LEN_W-1:0] rx_len = '0;
    logic host_ack = 1'b0;
    logic fw_hsnak_clr = 1'b0, fw_stall_set = 1'b0, fw_in_arm = 1'b0, fw_out_arm = 1'b0;
    logic [LEN_W-1:0] fw_in_len = '0;
    logic [2:0] fw_irq_clr = 3'd0;
    logic resp_valid, tx_data1, hsnak, stall;
    logic [1:0] resp_code;
    logic [LEN_W-1:0] tx_len;
    logic [2:0] ctl_state, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctl_ep_seq #(.LEN_W(LEN_W)) u_ctl_ep_seq (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_kind(tok_kind),
        .rx_valid(rx_valid), .rx_data1(rx_data1), .rx_len(rx_len),
        .host_ack(host_ack), .fw_hsnak_clr(fw_hsnak_clr), .fw_stall_set(fw_stall_set),
        .fw_in_arm(fw_in_arm), .fw_in_len(fw_in_len), .fw_out_arm(fw_out_arm),
        .fw_irq_clr(fw_irq_clr), .resp_valid(resp_valid), .resp_code(resp_code),
        .tx_data1(tx_data1), .tx_len(tx_len), .ctl_state(ctl_state),
        .hsnak(hsnak), .stall(stall), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Every stimulus task starts and ends on a falling edge; outputs are then settled.
    task automatic idle_cycle();
        @(negedge clk);
    endtask

    task automatic tok(input int kind);
        tok_valid = 1'b1; tok_kind = 2'(kind);
        @(negedge clk);
        tok_valid = 1'b0;
    endtask

    task automatic rx(input bit d1, input int len);
        rx_valid = 1'b1; rx_data1 = d1; rx_len = LEN_W'(len);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic hack();
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
    endtask

    task automatic fw_clr_hsnak();
        fw_hsnak_clr = 1'b1;
        @(negedge clk);
        fw_hsnak_clr = 1'b0;
    endtask

    task automatic fw_stall();
        fw_stall_set = 1'b1;
        @(negedge clk);
        fw_stall_set = 1'b0;
    endtask

    task automatic fw_arm_in(input int len);
        fw_in_arm = 1'b1; fw_in_len = LEN_W'(len);
        @(negedge clk);
        fw_in_arm = 1'b0;
    endtask

    task automatic fw_arm_out();
        fw_out_arm = 1'b1;
        @(negedge clk);
        fw_out_arm = 1'b0;
    endtask

    task automatic fw_clr_irq(input int mask);
        fw_irq_clr = 3'(mask);
        @(negedge clk);
        fw_irq_clr = 3'd0;
    endtask

    task automatic resp(input string req, input int code);
        chk({req, " resp_valid"}, int'(resp_valid), 1);
        chk({req, " resp_code"}, int'(resp_code), code);
    endtask

    task automatic open_transfer();
        tok(0);
        rx(1'b0, 8);
        fw_clr_irq(7);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_cycle();
        // R1 reset state
        chk("R1 state", int'(ctl_state), 0);
        chk("R1 resp_valid", int'(resp_valid), 0);
        chk("R1 hsnak", int'(hsnak), 0);
        chk("R1 stall", int'(stall), 0);
        chk("R1 irq", int'(irq), 0);

        // R10 idle answers NAK
        tok(1); resp("R10 idle IN", R_NAK);
        rx(1'b0, 3); resp("R10 idle OUT", R_NAK);
        idle_cycle(); chk("R11 one-cycle strobe", int'(resp_valid), 0);

        // R3 sweep of setup packet length and PID
        for (int len = 0; len < 16; len++) begin
            for (int p = 0; p < 2; p++) begin
                tok(0);
                chk("R2 state", int'(ctl_state), 1);
                chk("R2 irq0", int'(irq[0]), 1);
                chk("R2 hsnak", int'(hsnak), 1);
                rx(p[0], len);
                if (len == 8 && p == 0) begin
                    resp("R3 good setup", R_ACK);
                    chk("R3 state", int'(ctl_state), 2);
                    chk("R3 irq1", int'(irq[1]), 1);
                end else begin
                    chk("R3 bad setup no resp", int'(resp_valid), 0);
                    chk("R3 bad setup state", int'(ctl_state), 0);
                    chk("R3 bad setup irq1", int'(irq[1]), 0);
                end
                fw_clr_irq(7);
                chk("R9 cleared", int'(irq), 0);
            end
        end

        // R4 IN data stages of 1..4 packets, then OUT status
        for (int n = 1; n <= 4; n++) begin
            open_transfer();
            for (int k = 0; k < n; k++) begin
                int plen = (k * 7 + 3 + n) % 64;
                fw_arm_in(plen);
                tok(1);
                resp("R4 IN data", R_DATA);
                chk("R4 pid", int'(tx_data1), (k % 2 == 0) ? 1 : 0);
                chk("R4 len", int'(tx_len), plen);
                chk("R4 state", int'(ctl_state), 3);
                if (k == 0) begin
                    tok(1);
                    resp("R4 retry", R_DATA);
                    chk("R4 retry pid", int'(tx_data1), 1);
                end
                hack();
                chk("R4 irq2", int'(irq[2]), 1);
                chk("R4 back to open", int'(ctl_state), 2);
                fw_clr_irq(4);
            end
            tok(1); resp("R6 IN unarmed held", R_NAK);
            rx(1'b1, 0); resp("R6 status OUT held", R_NAK);
            chk("R6 hsnak", int'(hsnak), 1);
            fw_clr_hsnak();
            chk("R7 hsnak cleared", int'(hsnak), 0);
            rx(1'b1, 0); resp("R7 status OUT", R_ACK);
            chk("R7 to idle", int'(ctl_state), 0);
        end

        // R5 OUT data stage with stale PIDs, then IN status
        open_transfer();
        rx(1'b1, 5); resp("R6 OUT unarmed", R_NAK);
        fw_arm_out();
        rx(1'b0, 5); resp("R5 stale pid ack", R_ACK);
        rx(1'b1, 5); resp("R5 good pid after stale", R_ACK);
        rx(1'b0, 5); resp("R5 disarmed NAK", R_NAK);
        fw_arm_out();
        rx(1'b0, 4); resp("R5 second packet DATA0", R_ACK);
        fw_arm_out();
        rx(1'b0, 4); resp("R5 stale DATA0", R_ACK);
        rx(1'b1, 4); resp("R5 third packet DATA1", R_ACK);
        tok(1); resp("R6 status IN held", R_NAK);
        fw_clr_hsnak();
        tok(1); resp("R7 status IN", R_DATA);
        chk("R7 status pid", int'(tx_data1), 1);
        chk("R7 status len", int'(tx_len), 0);
        chk("R7 state", int'(ctl_state), 4);
        hack();
        chk("R7 status done", int'(ctl_state), 0);
        chk("R7 no irq2 on status", int'(irq[2]), 0);

        // R8 stall in data stage and in idle
        open_transfer();
        fw_arm_in(9);
        fw_stall();
        chk("R8 stall set", int'(stall), 1);
        tok(1); resp("R8 IN stalled", R_STALL);
        rx(1'b1, 2); resp("R8 OUT stalled", R_STALL);
        tok(0);
        chk("R8 setup clears stall", int'(stall), 0);
        fw_stall();
        rx(1'b0, 8); resp("R3 setup ACK despite stall", R_ACK);
        tok(1); resp("R8 stall after setup", R_STALL);
        tok(0); rx(1'b0, 8); rx(1'b1, 0);
        resp("R7 status OUT right after hsnak", R_NAK);
        fw_clr_hsnak(); rx(1'b1, 0);
        chk("R7 idle", int'(ctl_state), 0);
        fw_stall();
        tok(1); resp("R10 idle stalled", R_STALL);

        // R2 abort mid transfer discards armed IN count
        open_transfer();
        fw_arm_in(12);
        tok(0);
        chk("R2 abort state", int'(ctl_state), 1);
        rx(1'b0, 8);
        tok(1); resp("R2 arm discarded", R_NAK);

        // R9 set wins over clear, hold-bit set wins over clear
        fw_clr_hsnak();
        tok_valid = 1'b1; tok_kind = 2'd0; fw_irq_clr = 3'b001; fw_hsnak_clr = 1'b1;
        @(negedge clk);
        tok_valid = 1'b0; fw_irq_clr = 3'd0; fw_hsnak_clr = 1'b0;
        chk("R9 irq0 set wins", int'(irq[0]), 1);
        chk("R9 hsnak set wins", int'(hsnak), 1);
        rx_valid = 1'b1; rx_data1 = 1'b0; rx_len = 7'd8; fw_irq_clr = 3'b010;
        @(negedge clk);
        rx_valid = 1'b0; fw_irq_clr = 3'd0;
        chk("R9 irq1 set wins", int'(irq[1]), 1);
        fw_clr_irq(3);
        chk("R9 w1c", int'(irq), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule